// File: doc/BRIEF.md
# Privileged Return and Trap-Check Unit

This unit executes the four privileged control operations of a RISC-V style hart: supervisor return, machine return, wait-for-interrupt and the address-translation fence. Each operation arrives as a decoded class together with a valid strobe. Alongside it come the hart's current privilege level, its machine status word, both saved exception PCs, a flag that says whether compressed instructions are enabled, and a flag that selects the newer privileged-spec rules.

The unit checks whether the operation is legal in the current context. That check looks at privilege level, the trap-return, timeout-wait and virtual-memory trap bits, and the alignment of the return target. It then either reports exactly one trap cause, or commits the architectural effect. The effect can be a new privilege level, an updated status word and a PC redirect, a halt request, or a one-cycle TLB flush. Every output is registered, so results appear on the clock edge after the strobe. The surrounding pipeline takes care of trap entry, CSR storage and the TLB itself.

Top module: `priv_ctrl_unit`

## Requirements
- R1: While and just after reset, `priv_o` is machine level (2'b11), `mstatus_o` and `pc_o` are zero, and `illegal_o`, `misalign_o`, `redirect_o`, `halt_o` and `flush_o` are low.
- R2: Operation codes are SRET=2'd0, MRET=2'd1, WFI=2'd2, SFENCE=2'd3, and privilege codes are U=2'b00, S=2'b01, M=2'b11. SRET issued at user level raises `illegal_o`, and MRET issued below machine level raises `illegal_o`.
- R3: SRET raises `illegal_o` whenever `new_spec_i` is 1 and the trap-return bit (mstatus bit 22) is set, at any privilege level. With `new_spec_i` at 0, that bit has no effect.
- R4: When `rvc_en_i` is 0 and bits [1:0] of the return target (sepc for SRET, mepc for MRET) are nonzero, a legally privileged return raises `misalign_o` and does not return. When `rvc_en_i` is 1, no alignment check is made.
- R5: A successful SRET under the newer rules does the following: it sets `priv_o` to {1'b0, SPP}, where SPP is bit 8; it copies SPIE (bit 5) into SIE (bit 1); it clears SPIE and SPP; it keeps every other status bit; and it redirects to sepc.
- R6: A successful MRET under the newer rules does the following: it sets `priv_o` to MPP (bits 12:11); it copies MPIE (bit 7) into MIE (bit 3); it clears MPIE and MPP to zero; it keeps every other status bit; and it redirects to mepc.
- R7: Under the older rules (`new_spec_i`=0), a successful return copies the saved enable bit into status bit number p instead of SIE or MIE, where p is the restored privilege value (UIE is bit 0). The clearing of SPIE/SPP or MPIE/MPP is unchanged.
- R8: WFI issued at supervisor level, with `new_spec_i`=1 and the timeout-wait bit (mstatus bit 21) set, raises `illegal_o`. In every other case WFI raises a one-cycle `halt_o`.
- R9: SFENCE issued at supervisor level, with `new_spec_i`=1 and the VM-trap bit (mstatus bit 20) set, raises `illegal_o`. In every other case SFENCE raises a one-cycle `flush_o`.
- R10: A trap leaves `priv_o` equal to the input privilege and `mstatus_o` equal to the input status word, and produces no redirect, halt or flush. At most one of `illegal_o` and `misalign_o` is set, and a privilege violation wins over misalignment.
- R11: Outputs change on the first clock edge after `valid_i`. Each of `illegal_o`, `misalign_o`, `redirect_o`, `halt_o` and `flush_o` is high for one cycle only. While `valid_i` is low, `priv_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation class |
| cur_priv_i | input | 2 | Current privilege level |
| mstatus_i | input | XLEN | Current machine status word |
| sepc_i | input | XLEN | Supervisor saved PC |
| mepc_i | input | XLEN | Machine saved PC |
| rvc_en_i | input | 1 | Compressed instructions enabled |
| new_spec_i | input | 1 | Newer privileged-spec rules selected |
| priv_o | output | 2 | Next privilege level |
| mstatus_o | output | XLEN | Updated status word |
| pc_o | output | XLEN | Redirect target |
| redirect_o | output | 1 | One-cycle redirect pulse |
| illegal_o | output | 1 | Illegal-instruction trap pulse |
| misalign_o | output | 1 | Instruction-address-misaligned trap pulse |
| halt_o | output | 1 | Halt request pulse |
| flush_o | output | 1 | TLB-flush pulse |

## Verification
The bench builds the unit with XLEN=64. This puts status bits and return-target bits above bit 31 in play, so the tests can show that a return carries high status bits through untouched and forwards a full-width saved PC. Bit positions below 23 stay where they are, so the directed scenarios cover both spec-rule settings, every privilege level, and each trap cause. They also cover the priority between privilege and alignment.

// File: rtl/priv_pkg.sv
// Package: shared codes and status-word bit positions for the privileged
// control unit. Assumes a status word of at least 23 bits.
package priv_pkg;

    typedef enum logic [1:0] {
        OP_SRET   = 2'd0,
        OP_MRET   = 2'd1,
        OP_WFI    = 2'd2,
        OP_SFENCE = 2'd3
    } op_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int B_UIE  = 0;
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;
    localparam int B_TVM  = 20;
    localparam int B_TW   = 21;
    localparam int B_TSR  = 22;

endpackage

// File: rtl/priv_legality.sv
// Module: decides whether a privileged operation is legal and picks the
// return target. Privilege-type faults rank above the alignment fault, so
// at most one fault output is ever high. Purely combinational.
module priv_legality
    import priv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] mstatus_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic            rvc_en_i,
    input  logic            new_spec_i,
    output logic            illegal_o,
    output logic            misalign_o,
    output logic [XLEN-1:0] target_o
);

    logic in_s;
    logic is_ret;
    logic priv_fault;

    // Classify privilege-type faults per operation.
    always_comb begin
        in_s       = (cur_priv_i == PRIV_S);
        priv_fault = 1'b0;
        unique case (op_i)
            OP_SRET:   priv_fault = (cur_priv_i == PRIV_U) ||
                                    (new_spec_i && mstatus_i[B_TSR]);
            OP_MRET:   priv_fault = (cur_priv_i != PRIV_M);
            OP_WFI:    priv_fault = in_s && new_spec_i && mstatus_i[B_TW];
            OP_SFENCE: priv_fault = in_s && new_spec_i && mstatus_i[B_TVM];
            default:   priv_fault = 1'b0;
        endcase
    end

    // Select the return target and apply the alignment check below privilege.
    always_comb begin
        is_ret     = (op_i == OP_SRET) || (op_i == OP_MRET);
        target_o   = (op_i == OP_SRET) ? sepc_i : mepc_i;
        illegal_o  = priv_fault;
        misalign_o = is_ret && !priv_fault && !rvc_en_i && (target_o[1:0] != 2'b00);
    end

endmodule

// File: rtl/priv_xret_update.sv
// Module: computes the privilege and status word that a successful SRET or
// MRET leaves behind, under either spec rule set. Combinational; the caller
// decides whether the result is committed.
module priv_xret_update
    import priv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            is_sret_i,
    input  logic [XLEN-1:0] mstatus_i,
    input  logic            new_spec_i,
    output logic [XLEN-1:0] mstatus_o,
    output logic [1:0]      priv_o
);

    logic [1:0] prev;
    logic       saved_en;

    // Pick the saved privilege and saved enable bit for the return kind.
    always_comb begin
        if (is_sret_i) begin
            prev     = {1'b0, mstatus_i[B_SPP]};
            saved_en = mstatus_i[B_SPIE];
        end else begin
            prev     = mstatus_i[B_MPP +: 2];
            saved_en = mstatus_i[B_MPIE];
        end
    end

    // Restore the enable bit, then clear the saved enable and saved privilege.
    always_comb begin
        mstatus_o = mstatus_i;
        if (new_spec_i) begin
            if (is_sret_i) mstatus_o[B_SIE] = saved_en;
            else           mstatus_o[B_MIE] = saved_en;
        end else begin
            mstatus_o[B_UIE + int'(prev)] = saved_en;
        end
        if (is_sret_i) begin
            mstatus_o[B_SPIE] = 1'b0;
            mstatus_o[B_SPP]  = 1'b0;
        end else begin
            mstatus_o[B_MPIE]      = 1'b0;
            mstatus_o[B_MPP +: 2]  = PRIV_U;
        end
        priv_o = prev;
    end

endmodule

// File: rtl/priv_ctrl_unit.sv
// Module: top of the privileged control unit. Registers the legality verdict
// and the committed effect one cycle after each valid strobe. Assumes the
// caller feeds the privilege and status outputs back as the next inputs.
module priv_ctrl_unit
    import priv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [1:0]      op_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] mstatus_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic            rvc_en_i,
    input  logic            new_spec_i,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] pc_o,
    output logic            redirect_o,
    output logic            illegal_o,
    output logic            misalign_o,
    output logic            halt_o,
    output logic            flush_o
);

    op_e             op;
    logic            illegal_c;
    logic            misalign_c;
    logic [XLEN-1:0] target_c;
    logic [XLEN-1:0] ret_mstatus_c;
    logic [1:0]      ret_priv_c;
    logic            commit_ret;
    logic            commit_wfi;
    logic            commit_fence;

    assign op = op_e'(op_i);

    priv_legality #(.XLEN(XLEN)) u_legal (
        .op_i       (op),
        .cur_priv_i (cur_priv_i),
        .mstatus_i  (mstatus_i),
        .sepc_i     (sepc_i),
        .mepc_i     (mepc_i),
        .rvc_en_i   (rvc_en_i),
        .new_spec_i (new_spec_i),
        .illegal_o  (illegal_c),
        .misalign_o (misalign_c),
        .target_o   (target_c)
    );

    priv_xret_update #(.XLEN(XLEN)) u_xret (
        .is_sret_i  (op == OP_SRET),
        .mstatus_i  (mstatus_i),
        .new_spec_i (new_spec_i),
        .mstatus_o  (ret_mstatus_c),
        .priv_o     (ret_priv_c)
    );

    // Gate every architectural effect on a fault-free valid operation.
    always_comb begin
        commit_ret   = valid_i && !illegal_c && !misalign_c &&
                       ((op == OP_SRET) || (op == OP_MRET));
        commit_wfi   = valid_i && !illegal_c && (op == OP_WFI);
        commit_fence = valid_i && !illegal_c && (op == OP_SFENCE);
    end

    // Register outputs; pulses last one cycle, state holds without a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_o     <= PRIV_M;
            mstatus_o  <= '0;
            pc_o       <= '0;
            redirect_o <= 1'b0;
            illegal_o  <= 1'b0;
            misalign_o <= 1'b0;
            halt_o     <= 1'b0;
            flush_o    <= 1'b0;
        end else begin
            redirect_o <= commit_ret;
            illegal_o  <= valid_i && illegal_c;
            misalign_o <= valid_i && misalign_c;
            halt_o     <= commit_wfi;
            flush_o    <= commit_fence;
            if (valid_i) begin
                priv_o    <= commit_ret ? ret_priv_c : cur_priv_i;
                mstatus_o <= commit_ret ? ret_mstatus_c : mstatus_i;
            end
            if (commit_ret) begin
                pc_o <= target_c;
            end
        end
    end

    AST_RESET_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (priv_o == PRIV_M)); // R1
    AST_SRET_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'd0 && cur_priv_i == 2'b00) |=> illegal_o); // R2
    AST_MRET_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'd1 && cur_priv_i != 2'b11) |=> illegal_o); // R2
    AST_TSR_BLOCKS_SRET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'd0 && new_spec_i && mstatus_i[22]) |=> (illegal_o && !redirect_o)); // R3
    AST_MISALIGN_ONLY_NO_RVC: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> !$past(rvc_en_i)); // R4
    AST_WFI_MACHINE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'd2 && cur_priv_i == 2'b11) |=> halt_o); // R8
    AST_TVM_BLOCKS_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'd3 && cur_priv_i == 2'b01 && new_spec_i && mstatus_i[20])
        |=> (illegal_o && !flush_o)); // R9
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_o && misalign_o)); // R10
    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || misalign_o) |-> !(redirect_o || halt_o || flush_o)); // R10
    AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || misalign_o || redirect_o || halt_o || flush_o) |-> $past(valid_i)); // R11
    AST_PRIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> $stable(priv_o)); // R11

endmodule

// File: tb/priv_ctrl_unit_tb.sv
module priv_ctrl_unit_tb;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            valid_i;
    logic [1:0]      op_i;
    logic [1:0]      cur_priv_i;
    logic [XLEN-1:0] mstatus_i;
    logic [XLEN-1:0] sepc_i;
    logic [XLEN-1:0] mepc_i;
    logic            rvc_en_i;
    logic            new_spec_i;
    logic [1:0]      priv_o;
    logic [XLEN-1:0] mstatus_o;
    logic [XLEN-1:0] pc_o;
    logic            redirect_o, illegal_o, misalign_o, halt_o, flush_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    priv_ctrl_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .cur_priv_i(cur_priv_i), .mstatus_i(mstatus_i), .sepc_i(sepc_i),
        .mepc_i(mepc_i), .rvc_en_i(rvc_en_i), .new_spec_i(new_spec_i),
        .priv_o(priv_o), .mstatus_o(mstatus_o), .pc_o(pc_o),
        .redirect_o(redirect_o), .illegal_o(illegal_o), .misalign_o(misalign_o),
        .halt_o(halt_o), .flush_o(flush_o)
    );

    task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one strobed operation, sample results on the following falling edge.
    task automatic issue(logic [1:0] op, logic [1:0] pr, logic [XLEN-1:0] ms,
                         logic [XLEN-1:0] sp, logic [XLEN-1:0] mp, logic rvc, logic ns);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; cur_priv_i = pr; mstatus_i = ms;
        sepc_i = sp; mepc_i = mp; rvc_en_i = rvc; new_spec_i = ns;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic chk_pulses(string req, logic ex_ill, logic ex_mis, logic ex_red,
                              logic ex_halt, logic ex_fl);
        chk(req, "illegal",  XLEN'(illegal_o),  XLEN'(ex_ill));
        chk(req, "misalign", XLEN'(misalign_o), XLEN'(ex_mis));
        chk(req, "redirect", XLEN'(redirect_o), XLEN'(ex_red));
        chk(req, "halt",     XLEN'(halt_o),     XLEN'(ex_halt));
        chk(req, "flush",    XLEN'(flush_o),    XLEN'(ex_fl));
    endtask

    task automatic t_reset();
        chk("R1", "priv", XLEN'(priv_o), 64'h3);
        chk("R1", "mstatus", mstatus_o, 64'h0);
        chk("R1", "pc", pc_o, 64'h0);
        chk_pulses("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_sret_new();
        issue(2'd0, 2'b01, 64'h0000_0100_0000_0128, 64'h0000_0080_0000_1004, 64'h0, 1'b0, 1'b1);
        chk("R5", "priv", XLEN'(priv_o), 64'h1);
        chk("R5", "mstatus", mstatus_o, 64'h0000_0100_0000_000A);
        chk("R5", "pc", pc_o, 64'h0000_0080_0000_1004);
        chk_pulses("R5", 0, 0, 1, 0, 0);
        issue(2'd0, 2'b11, 64'h2, 64'h200, 64'h0, 1'b0, 1'b1);
        chk("R5", "priv to user", XLEN'(priv_o), 64'h0);
        chk("R5", "mstatus SIE cleared", mstatus_o, 64'h0);
    endtask

    task automatic t_mret_new();
        issue(2'd1, 2'b11, 64'h880, 64'h0, 64'hFFFF_0000_0000_2000, 1'b0, 1'b1);
        chk("R6", "priv", XLEN'(priv_o), 64'h1);
        chk("R6", "mstatus", mstatus_o, 64'h8);
        chk("R6", "pc", pc_o, 64'hFFFF_0000_0000_2000);
        chk_pulses("R6", 0, 0, 1, 0, 0);
        issue(2'd1, 2'b11, 64'h1888, 64'h0, 64'h40, 1'b0, 1'b1);
        chk("R6", "priv machine", XLEN'(priv_o), 64'h3);
        chk("R6", "mstatus", mstatus_o, 64'h8);
    endtask

    task automatic t_old_spec();
        issue(2'd0, 2'b01, 64'h20, 64'h100, 64'h0, 1'b0, 1'b0);
        chk("R7", "sret UIE", mstatus_o, 64'h1);
        chk("R7", "sret priv", XLEN'(priv_o), 64'h0);
        issue(2'd1, 2'b11, 64'h880, 64'h0, 64'h100, 1'b0, 1'b0);
        chk("R7", "mret bit1", mstatus_o, 64'h2);
        chk("R7", "mret priv", XLEN'(priv_o), 64'h1);
        issue(2'd1, 2'b11, 64'h1880, 64'h0, 64'h100, 1'b0, 1'b0);
        chk("R7", "mret bit3", mstatus_o, 64'h8);
    endtask

    task automatic t_priv_illegal();
        issue(2'd0, 2'b00, 64'h128, 64'h100, 64'h0, 1'b0, 1'b1);
        chk_pulses("R2", 1, 0, 0, 0, 0);
        chk("R10", "priv kept", XLEN'(priv_o), 64'h0);
        chk("R10", "mstatus kept", mstatus_o, 64'h128);
        issue(2'd1, 2'b01, 64'h880, 64'h0, 64'h100, 1'b0, 1'b1);
        chk_pulses("R2", 1, 0, 0, 0, 0);
        chk("R10", "priv kept", XLEN'(priv_o), 64'h1);
        chk("R10", "mstatus kept", mstatus_o, 64'h880);
    endtask

    task automatic t_tsr();
        issue(2'd0, 2'b01, 64'h0040_0120, 64'h100, 64'h0, 1'b0, 1'b1);
        chk_pulses("R3", 1, 0, 0, 0, 0);
        issue(2'd0, 2'b11, 64'h0040_0000, 64'h100, 64'h0, 1'b0, 1'b1);
        chk_pulses("R3", 1, 0, 0, 0, 0);
        issue(2'd0, 2'b01, 64'h0040_0120, 64'h100, 64'h0, 1'b0, 1'b0);
        chk_pulses("R3", 0, 0, 1, 0, 0);
        chk("R3", "old rules mstatus", mstatus_o, 64'h0040_0002);
    endtask

    task automatic t_misalign();
        issue(2'd1, 2'b11, 64'h880, 64'h0, 64'h102, 1'b0, 1'b1);
        chk_pulses("R4", 0, 1, 0, 0, 0);
        chk("R10", "mstatus kept", mstatus_o, 64'h880);
        chk("R10", "priv kept", XLEN'(priv_o), 64'h3);
        issue(2'd1, 2'b11, 64'h880, 64'h0, 64'h102, 1'b1, 1'b1);
        chk_pulses("R4", 0, 0, 1, 0, 0);
        chk("R4", "pc compressed", pc_o, 64'h102);
        issue(2'd0, 2'b01, 64'h0, 64'h101, 64'h0, 1'b0, 1'b1);
        chk_pulses("R4", 0, 1, 0, 0, 0);
        issue(2'd0, 2'b00, 64'h0, 64'h103, 64'h0, 1'b0, 1'b1);
        chk_pulses("R10", 1, 0, 0, 0, 0);
    endtask

    task automatic t_wfi();
        issue(2'd2, 2'b01, 64'h0020_0000, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R8", 1, 0, 0, 0, 0);
        issue(2'd2, 2'b01, 64'h0020_0000, 64'h0, 64'h0, 1'b0, 1'b0);
        chk_pulses("R8", 0, 0, 0, 1, 0);
        issue(2'd2, 2'b11, 64'h0020_0000, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R8", 0, 0, 0, 1, 0);
        issue(2'd2, 2'b00, 64'h0020_0000, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R8", 0, 0, 0, 1, 0);
        chk("R8", "priv unchanged", XLEN'(priv_o), 64'h0);
    endtask

    task automatic t_sfence();
        issue(2'd3, 2'b01, 64'h0010_0000, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R9", 1, 0, 0, 0, 0);
        issue(2'd3, 2'b01, 64'h0, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R9", 0, 0, 0, 0, 1);
        issue(2'd3, 2'b11, 64'h0010_0000, 64'h0, 64'h0, 1'b0, 1'b1);
        chk_pulses("R9", 0, 0, 0, 0, 1);
    endtask

    task automatic t_timing();
        issue(2'd3, 2'b01, 64'h0, 64'h0, 64'h0, 1'b0, 1'b1);
        chk("R11", "flush first cycle", XLEN'(flush_o), 64'h1);
        chk("R11", "priv after fence", XLEN'(priv_o), 64'h1);
        cur_priv_i = 2'b00; op_i = 2'd0; mstatus_i = 64'h20;
        @(negedge clk);
        chk_pulses("R11", 0, 0, 0, 0, 0);
        chk("R11", "priv held", XLEN'(priv_o), 64'h1);
        @(negedge clk);
        chk("R11", "mstatus held", mstatus_o, 64'h0);
    endtask

    initial begin
        rst_n = 1'b0; valid_i = 1'b0; op_i = 2'd0; cur_priv_i = 2'b11;
        mstatus_i = '0; sepc_i = '0; mepc_i = '0; rvc_en_i = 1'b0; new_spec_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sret_new();
        t_mret_new();
        t_old_spec();
        t_priv_illegal();
        t_tsr();
        t_misalign();
        t_wfi();
        t_sfence();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule